// File: doc/BRIEF.md
# Three-Moduli Binary-to-Residue Converter

This block turns an unsigned binary word of 6n bits into its three residues for the moduli 2^2n-1, 2^2n and 2^2n+1, where n is a parameter. The word is cut into three 2n-bit slices. The residue modulo 2^2n is the low slice taken as it is. The other two residues come from short chains of modular adders. Because 2^2n is congruent to +1 modulo 2^2n-1 and to -1 modulo 2^2n+1, the slices are simply summed for the first modulus. For the second modulus the middle slice is subtracted instead. No multiplier and no divider is used.

A word enters with a valid flag. The three residues leave with their own valid flag, either in the same cycle or one cycle later, chosen by a parameter. The block sits in front of residue-domain datapaths that need their operands in this three-channel form.

Top module: `rns3_fwd_conv`

## Requirements
- R1: `res_pow` equals the 2n least significant bits of the accepted word (X mod 2^2n).
- R2: `res_m1` equals X mod (2^2n-1) and always lies in [0, 2^2n-2]; the all-ones code never appears while `out_valid` is 1.
- R3: `res_m3` equals X mod (2^2n+1) and always lies in [0, 2^2n].
- R4: With `REG_OUT`=1, `out_valid` rises or stays low exactly one clock after `in_valid` was sampled high or low, and the residues of that word appear with it. With `REG_OUT`=0, outputs follow the input in the same cycle.
- R5: While `rst_n` is 0, `out_valid` is 0 whatever `in_valid` does, and an accepted word that is in flight when reset is asserted never appears as valid.
- R6: For n=1 and X=22 the residues are `res_m1`=1, `res_pow`=2, `res_m3`=2.
- R7: A word of all ones gives `res_m1`=0, `res_pow`=2^2n-1 and `res_m3`=2^2n-1.
- R8: A word whose middle slice is all ones and whose other slices are zero (for n=4, X=0x00FF00) gives `res_m1`=0 and `res_m3`=2, exercising the negative-result correction of the 2^2n+1 path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Input word is valid this cycle |
| in_word | input | 6n | Unsigned binary word X |
| out_valid | output | 1 | Residues are valid |
| res_m1 | output | 2n | X mod (2^2n-1) |
| res_pow | output | 2n | X mod 2^2n |
| res_m3 | output | 2n+1 | X mod (2^2n+1) |

## Verification
A fault in either adder chain shows at the ports as a residue that disagrees with the integer remainder of the same word, or as an out-of-range code. Examples are an all-ones `res_m1` or a `res_m3` above 2^2n. It becomes visible in the cycle `out_valid` carries that word: the same cycle without the output register, one clock later with it. A corrupted valid register appears on the next clock as `out_valid` that does not match the previous `in_valid`. Exhaustive n=1 words and targeted slice patterns for n=4 reach both correction branches of the 2^2n+1 path and the folding of an all-ones sum in the 2^2n-1 path.

// File: rtl/rns3_pkg.sv
`timescale 1ns/1ps
package rns3_pkg;

  // Operation performed by a modulo (2^W+1) adder stage
  typedef enum logic {
    M3_ADD = 1'b0,
    M3_SUB = 1'b1
  } m3_op_e;

endpackage

// File: rtl/rns3_m1_add.sv
`timescale 1ns/1ps
// Modulo (2^W-1) adder with end-around carry.
// NORM=1 maps the redundant all-ones code (which stands for zero) to zero.
module rns3_m1_add #(
  parameter int unsigned W    = 8,
  parameter bit          NORM = 1'b0
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] s
);

  logic [W:0]   wide;
  logic [W-1:0] folded;

  // The carry out has weight 2^W, which is congruent to 1: add it back in.
  // a+b <= 2^(W+1)-2, so the folded value never overflows W bits.
  always_comb begin
    wide   = {1'b0, a} + {1'b0, b};
    folded = wide[W-1:0] + W'(wide[W]);
  end

  generate
    if (NORM) begin : g_norm
      assign s = (&folded) ? '0 : folded;
    end else begin : g_raw
      assign s = folded;
    end
  endgenerate

endmodule

// File: rtl/rns3_m3_addsub.sv
`timescale 1ns/1ps
// Modulo (2^W+1) adder or subtractor on operands in [0, 2^W].
// One correction step: add the modulus if negative, subtract it if too large.
module rns3_m3_addsub
  import rns3_pkg::*;
#(
  parameter int unsigned W  = 8,
  parameter m3_op_e      OP = M3_ADD
) (
  input  logic [W:0] a,
  input  logic [W:0] b,
  output logic [W:0] s
);

  localparam int unsigned EW  = W + 3;
  localparam int unsigned M3I = (1 << W) + 1;
  localparam logic signed [EW-1:0] M3S = EW'(M3I);

  logic signed [EW-1:0] ea;
  logic signed [EW-1:0] eb;
  logic signed [EW-1:0] raw;
  logic signed [EW-1:0] fix;
  logic [EW-W-2:0]      unused_fix_hi;

  assign ea = $signed({2'b00, a});
  assign eb = $signed({2'b00, b});

  generate
    if (OP == M3_SUB) begin : g_sub
      assign raw = ea - eb;
    end else begin : g_add
      assign raw = ea + eb;
    end
  endgenerate

  always_comb begin
    if (raw < 0) begin
      fix = raw + M3S;
    end else if (raw >= M3S) begin
      fix = raw - M3S;
    end else begin
      fix = raw;
    end
  end

  assign {unused_fix_hi, s} = fix;

endmodule

// File: rtl/rns3_fwd_conv.sv
`timescale 1ns/1ps
// Binary to residue converter for the moduli {2^2n-1, 2^2n, 2^2n+1}.
module rns3_fwd_conv
  import rns3_pkg::*;
#(
  parameter int unsigned N       = 4,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [6*N-1:0] in_word,
  output logic           out_valid,
  output logic [2*N-1:0] res_m1,
  output logic [2*N-1:0] res_pow,
  output logic [2*N:0]   res_m3
);

  localparam int unsigned W  = 2 * N;
  localparam int unsigned XW = 3 * W;

  // Slices: word = hi*2^(2W) + mid*2^W + lo
  logic [W-1:0] blk_hi;
  logic [W-1:0] blk_mid;
  logic [W-1:0] blk_lo;

  assign blk_hi  = in_word[XW-1:2*W];
  assign blk_mid = in_word[2*W-1:W];
  assign blk_lo  = in_word[W-1:0];

  // Modulo 2^W-1 path: hi + mid + lo
  logic [W-1:0] m1_part;
  logic [W-1:0] m1_c;

  rns3_m1_add #(.W(W), .NORM(1'b0)) m1_stage0_i (
    .a (blk_hi),
    .b (blk_mid),
    .s (m1_part)
  );

  rns3_m1_add #(.W(W), .NORM(1'b1)) m1_stage1_i (
    .a (m1_part),
    .b (blk_lo),
    .s (m1_c)
  );

  // Modulo 2^W+1 path: hi - mid + lo
  logic [W:0] m3_part;
  logic [W:0] m3_c;

  rns3_m3_addsub #(.W(W), .OP(M3_SUB)) m3_stage0_i (
    .a ({1'b0, blk_hi}),
    .b ({1'b0, blk_mid}),
    .s (m3_part)
  );

  rns3_m3_addsub #(.W(W), .OP(M3_ADD)) m3_stage1_i (
    .a (m3_part),
    .b ({1'b0, blk_lo}),
    .s (m3_c)
  );

  // Output stage
  generate
    if (REG_OUT) begin : g_reg
      logic         vld_q, vld_d;
      logic [W-1:0] m1_q,  m1_d;
      logic [W-1:0] pow_q, pow_d;
      logic [W:0]   m3_q,  m3_d;

      always_comb begin
        vld_d = in_valid;
        m1_d  = m1_q;
        pow_d = pow_q;
        m3_d  = m3_q;
        if (in_valid) begin
          m1_d  = m1_c;
          pow_d = blk_lo;
          m3_d  = m3_c;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q <= 1'b0;
        end else begin
          vld_q <= vld_d;
        end
      end

      always_ff @(posedge clk) begin
        m1_q  <= m1_d;
        pow_q <= pow_d;
        m3_q  <= m3_d;
      end

      assign out_valid = vld_q;
      assign res_m1    = m1_q;
      assign res_pow   = pow_q;
      assign res_m3    = m3_q;
    end else begin : g_comb
      assign out_valid = in_valid;
      assign res_m1    = m1_c;
      assign res_pow   = blk_lo;
      assign res_m3    = m3_c;
    end
  endgenerate

endmodule

// File: rtl/rns3_fwd_chk.sv
`timescale 1ns/1ps
// Port-level checker for rns3_fwd_conv.
module rns3_fwd_chk #(
  parameter int unsigned N       = 4,
  parameter bit          REG_OUT = 1'b1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic [6*N-1:0] in_word,
  input logic           out_valid,
  input logic [2*N-1:0] res_m1,
  input logic [2*N-1:0] res_pow,
  input logic [2*N:0]   res_m3
);

  localparam int unsigned W  = 2 * N;
  localparam int unsigned XW = 6 * N;
  localparam logic [XW-1:0] M1X = XW'((1 << W) - 1);
  localparam logic [XW-1:0] M3X = XW'((1 << W) + 1);
  localparam logic [W:0]    M3TOP = (W+1)'(1 << W);

  logic [XW-1:0] x_q;
  logic [XW-1:0] x_ref;

  always_ff @(posedge clk) begin
    if (in_valid) begin
      x_q <= in_word;
    end
  end

  assign x_ref = REG_OUT ? x_q : in_word;

  // R1
  pow_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (res_pow == x_ref[W-1:0]));

  // R2
  m1_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ({{(XW-W){1'b0}}, res_m1} == (x_ref % M1X)));

  // R2
  m1_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (res_m1 != '1));

  // R3
  m3_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ({{(XW-W-1){1'b0}}, res_m3} == (x_ref % M3X)));

  // R3
  m3_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (res_m3 <= M3TOP));

  generate
    if (REG_OUT) begin : g_lat
      // R4
      lat_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

      // R4
      lat_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

      // R5
      rst_clear_chk: assert property (@(posedge clk)
        !rst_n |-> !out_valid);
    end
  endgenerate

endmodule

bind rns3_fwd_conv rns3_fwd_chk #(.N(N), .REG_OUT(REG_OUT)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_word   (in_word),
  .out_valid (out_valid),
  .res_m1    (res_m1),
  .res_pow   (res_pow),
  .res_m3    (res_m3)
);

// File: tb/rns3_fwd_conv_tb_top.sv
`timescale 1ns/1ps
module rns3_fwd_conv_tb_top;

  localparam int unsigned N   = 4;
  localparam int unsigned W   = 2 * N;
  localparam int unsigned XW  = 6 * N;
  localparam int unsigned NS  = 1;
  localparam int unsigned WS  = 2 * NS;
  localparam int unsigned XWS = 6 * NS;

  logic clk;
  logic rst_n;

  // Registered instance, n=4
  logic          in_valid;
  logic [XW-1:0] in_word;
  logic          out_valid;
  logic [W-1:0]  res_m1;
  logic [W-1:0]  res_pow;
  logic [W:0]    res_m3;

  // Combinational instance, n=1
  logic           s_in_valid;
  logic [XWS-1:0] s_in_word;
  logic           s_out_valid;
  logic [WS-1:0]  s_res_m1;
  logic [WS-1:0]  s_res_pow;
  logic [WS:0]    s_res_m3;

  int n_chk;
  int n_fail;
  bit done;

  // Expected state of the registered instance
  bit          pend_known;
  bit          pend_v;
  logic [XW-1:0] pend_x;

  rns3_fwd_conv #(.N(N), .REG_OUT(1'b1)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_word   (in_word),
    .out_valid (out_valid),
    .res_m1    (res_m1),
    .res_pow   (res_pow),
    .res_m3    (res_m3)
  );

  rns3_fwd_conv #(.N(NS), .REG_OUT(1'b0)) dut_n1_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (s_in_valid),
    .in_word   (s_in_word),
    .out_valid (s_out_valid),
    .res_m1    (s_res_m1),
    .res_pow   (s_res_pow),
    .res_m3    (s_res_m3)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input longint got, input longint exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  function automatic longint mod_of(input longint x, input longint m);
    return x % m;
  endfunction

  // Compare the registered outputs with the word driven one cycle earlier
  task automatic check_pending();
    longint x;
    longint pw;
    x  = longint'(pend_x);
    pw = longint'(1) << W;
    if (pend_known) begin
      check("R4 out_valid latency", longint'(out_valid), longint'(pend_v));
      if (pend_v) begin
        check("R1 res_pow", longint'(res_pow), mod_of(x, pw));
        check("R2 res_m1",  longint'(res_m1),  mod_of(x, pw - 1));
        check("R3 res_m3",  longint'(res_m3),  mod_of(x, pw + 1));
      end
    end
  endtask

  task automatic drive(input bit v, input logic [XW-1:0] x);
    @(negedge clk);
    check_pending();
    in_valid   = v;
    in_word    = x;
    pend_v     = v;
    pend_x     = x;
    pend_known = 1'b1;
  endtask

  task automatic drive_small(input bit v, input logic [XWS-1:0] x);
    longint xl;
    longint pw;
    @(negedge clk);
    s_in_valid = v;
    s_in_word  = x;
    #1;
    xl = longint'(x);
    pw = longint'(1) << WS;
    check("R4 same-cycle valid n=1", longint'(s_out_valid), longint'(v));
    if (v) begin
      check("R1 res_pow n=1", longint'(s_res_pow), mod_of(xl, pw));
      check("R2 res_m1 n=1",  longint'(s_res_m1),  mod_of(xl, pw - 1));
      check("R3 res_m3 n=1",  longint'(s_res_m3),  mod_of(xl, pw + 1));
    end
  endtask

  // Watchdog
  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk      = 0;
    n_fail     = 0;
    done       = 1'b0;
    pend_known = 1'b0;
    pend_v     = 1'b0;
    pend_x     = '0;
    rst_n      = 1'b1;
    in_valid   = 1'b1;
    in_word    = 24'h123456;
    s_in_valid = 1'b0;
    s_in_word  = '0;
    #1 rst_n = 1'b0;

    // R5: valid stays low during reset even with in_valid high
    repeat (3) @(negedge clk);
    check("R5 out_valid in reset", longint'(out_valid), 0);

    @(negedge clk);
    rst_n      = 1'b1;
    in_valid   = 1'b0;
    in_word    = '0;
    pend_v     = 1'b0;
    pend_x     = '0;
    pend_known = 1'b1;

    // Corner words
    drive(1'b1, 24'h000000);
    drive(1'b1, 24'hFFFFFF);
    @(negedge clk);
    // R7: all-ones word
    check("R7 res_m1 all ones", longint'(res_m1), 0);
    check("R7 res_pow all ones", longint'(res_pow), 255);
    check("R7 res_m3 all ones", longint'(res_m3), 255);
    check("R4 out_valid latency", longint'(out_valid), 1);
    in_valid   = 1'b1;
    in_word    = 24'h00FF00;
    pend_v     = 1'b1;
    pend_x     = 24'h00FF00;
    @(negedge clk);
    // R8: middle slice all ones
    check("R8 res_m1 mid ones", longint'(res_m1), 0);
    check("R8 res_m3 mid ones", longint'(res_m3), 2);
    in_valid = 1'b0;
    pend_v   = 1'b0;
    drive(1'b1, 24'hFF0000);
    drive(1'b1, 24'h0000FF);
    drive(1'b1, 24'hFFFF00);
    drive(1'b1, 24'h00FFFF);
    drive(1'b1, 24'hFF00FF);
    drive(1'b1, 24'h000101);
    drive(1'b1, 24'h010000);
    drive(1'b0, 24'hABCDEF);
    drive(1'b1, 24'hFEFFFE);
    drive(1'b1, 24'h000100);

    // Random words with random gaps
    for (int i = 0; i < 400; i++) begin
      drive(($urandom % 4) != 0, XW'($urandom));
    end
    drive(1'b0, '0);

    // R5: word in flight when reset hits must not appear
    drive(1'b1, 24'h5A5A5A);
    #2 rst_n = 1'b0;
    @(posedge clk);
    #2;
    check("R5 in-flight word dropped", longint'(out_valid), 0);
    @(negedge clk);
    rst_n      = 1'b1;
    in_valid   = 1'b0;
    pend_v     = 1'b0;
    pend_known = 1'b1;
    drive(1'b1, 24'h3C3C3C);
    drive(1'b0, '0);
    drive(1'b0, '0);

    // n=1 combinational instance: worked example, all words, valid low
    drive_small(1'b1, 6'd22);
    check("R6 res_m1 X=22", longint'(s_res_m1), 1);
    check("R6 res_pow X=22", longint'(s_res_pow), 2);
    check("R6 res_m3 X=22", longint'(s_res_m3), 2);
    drive_small(1'b1, 6'd63);
    check("R7 res_m1 n=1 all ones", longint'(s_res_m1), 0);
    check("R7 res_m3 n=1 all ones", longint'(s_res_m3), 3);
    for (int k = 0; k < 64; k++) begin
      drive_small(1'b1, XWS'(k));
    end
    drive_small(1'b0, 6'd5);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule